// File: doc/BRIEF.md
# Program Counter Steering Unit for Branches and Skips

This block works out where program flow goes after a control-transfer instruction, and how many cycles that instruction takes. The decode stage gives it the current program counter, a 4-bit instruction class, the offset field, the 16-bit Z pointer, the eight status flags, a flag selector and sense bit, the tested register or I/O bit, the compare-equal result, and a flag that says whether the instruction after this one is a two-word instruction. It returns the next program counter and a cycle count. The fetch control uses the cycle count to hold its pipeline for the right number of cycles.

Each request is presented for one cycle with `instValid` high. The next clock edge registers the result, and `resultValid` then pulses for one cycle. The outputs keep their values until the next request arrives. Pushing and popping return addresses, and fetching instructions, are handled by neighbouring logic. For a return, the block only reports the cycle cost and leaves the counter as it was, so the stack logic can overwrite it.

The program counter is 10 bits wide and counts words, so every address calculation wraps modulo 1024. The two offsets are signed values in two's complement. Relative jumps and calls use all 12 bits of `offset`. Conditional branches use only the low 7 bits, `offset[6:0]`.

Top module: `pc_steer_unit`

## Requirements
- R1: While `rstN` is low, and until the first accepted request after reset, `resultValid`, `nextPc` and `cycleCount` are all zero.
- R2: A request with `instValid` high produces its result one clock edge later, with `resultValid` high for exactly that one cycle. In a cycle with `instValid` low, `resultValid` stays low and `nextPc` and `cycleCount` keep their values, whatever the other inputs do.
- R3: Class 1 is a relative jump and class 2 is a relative call. Both give `nextPc` = `curPc` + sign-extended `offset[11:0]` + 1. The jump costs 2 cycles and the call costs 3.
- R4: Class 3 is an indirect jump and class 4 is an indirect call. Both give `nextPc` = `zPtr[9:0]`. The jump costs 2 cycles and the call costs 3.
- R5: Class 6 is a flag branch. The branch is taken when `statusBits[flagSel]` equals `senseSet`. When taken, `nextPc` = `curPc` + sign-extended `offset[6:0]` + 1 at a cost of 2 cycles, and `offset[11:7]` has no effect. When not taken, `nextPc` = `curPc` + 1 at a cost of 1 cycle.
- R6: Class 7 is a signed branch. Its condition is N XOR V, with N in `statusBits[2]` and V in `statusBits[3]`. With `senseSet` = 0 it is taken when the XOR is 0 (greater or equal). With `senseSet` = 1 it is taken when the XOR is 1 (less than). Target and cycle costs are the same as in R5.
- R7: Class 8 is an equality skip, taken when `regsEqual` is 1. When taken, `nextPc` = `curPc` + 3 at 3 cycles if `nextIsLong` is 1, and `curPc` + 2 at 2 cycles otherwise. When not taken, `nextPc` = `curPc` + 1 at 1 cycle.
- R8: Class 9 is a bit skip, taken when `testBit` equals `senseSet`. Its target and cost follow the same rules as R7.
- R9: Class 5 is a return. It leaves `nextPc` equal to `curPc` and costs 4 cycles.
- R10: Class 0, and the unused codes 10 to 15, are sequential. They give `nextPc` = `curPc` + 1 at 1 cycle.
- R11: Every target wraps modulo 1024. For example, 1023 + 0 + 1 gives 0, and 1022 + 3 gives 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| instValid | input | 1 | Request strobe |
| instClass | input | 4 | Instruction class code |
| curPc | input | 10 | Word address of the current instruction |
| offset | input | 12 | Signed offset field; branches use bits 6:0 |
| zPtr | input | 16 | Z pointer value |
| statusBits | input | 8 | Status flags (N at bit 2, V at bit 3) |
| flagSel | input | 3 | Flag tested by a flag branch |
| senseSet | input | 1 | Polarity of the branch or skip condition |
| testBit | input | 1 | Register or I/O bit tested by a bit skip |
| regsEqual | input | 1 | Compare-equal result for an equality skip |
| nextIsLong | input | 1 | The following instruction is two words long |
| nextPc | output | 10 | Registered next program counter |
| cycleCount | output | 3 | Registered cycle cost of the instruction |
| resultValid | output | 1 | Result strobe, one cycle after the request |

## Verification
The assertions check the following on every cycle:
- The result strobe follows the request by exactly one edge.
- Idle cycles leave the outputs unchanged.
- An indirect transfer lands on the low bits of the pointer.
- Each signed branch and skip decision maps onto the right target and cycle cost.
- A reported cycle count is never zero.

Only the bench's scenarios can show that the arithmetic is right. These scenarios include the sign extension of both offset widths, wrap-around at both ends of the address space, offset bits that a branch must ignore, and the two-word skip distance. They also show that the flag selector picks the correct status bit.

// File: rtl/pc_steer_pkg.sv
package pc_steer_pkg;

  localparam int CYC_W = 3;

  typedef enum logic [3:0] {
    CLS_SEQ     = 4'd0,
    CLS_RJMP    = 4'd1,
    CLS_RCALL   = 4'd2,
    CLS_IJMP    = 4'd3,
    CLS_ICALL   = 4'd4,
    CLS_RET     = 4'd5,
    CLS_BRFLAG  = 4'd6,
    CLS_BRSIGN  = 4'd7,
    CLS_SKIPEQ  = 4'd8,
    CLS_SKIPBIT = 4'd9
  } instClass_e;

  typedef enum logic [2:0] {
    TGT_INC1  = 3'd0,
    TGT_INC2  = 3'd1,
    TGT_INC3  = 3'd2,
    TGT_SHORT = 3'd3,
    TGT_LONG  = 3'd4,
    TGT_ZPTR  = 3'd5,
    TGT_HOLD  = 3'd6
  } target_e;

  typedef struct packed {
    logic             load;
    target_e          target;
    logic [CYC_W-1:0] cycles;
  } steer_t;

endpackage

// File: rtl/pc_steer_ctrl.sv
module pc_steer_ctrl
  import pc_steer_pkg::*;
#(
  parameter int STAT_W = 8,
  parameter int N_POS  = 2,
  parameter int V_POS  = 3,
  localparam int SEL_W = $clog2(STAT_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              instValid,
  input  logic [3:0]        instClass,
  input  logic [STAT_W-1:0] statusBits,
  input  logic [SEL_W-1:0]  flagSel,
  input  logic              senseSet,
  input  logic              testBit,
  input  logic              regsEqual,
  input  logic              nextIsLong,
  output steer_t            steer
);

  logic flagHit;
  logic signedHit;
  logic eqHit;
  logic bitHit;

  always_comb begin
    flagHit   = (statusBits[flagSel] == senseSet);
    signedHit = ((statusBits[N_POS] ^ statusBits[V_POS]) == senseSet);
    eqHit     = regsEqual;
    bitHit    = (testBit == senseSet);
  end

  function automatic steer_t skipSteer(input logic hit, input logic longNext);
    steer_t s;
    s.load = 1'b0;
    if (!hit) begin
      s.target = TGT_INC1;
      s.cycles = CYC_W'(1);
    end else if (longNext) begin
      s.target = TGT_INC3;
      s.cycles = CYC_W'(3);
    end else begin
      s.target = TGT_INC2;
      s.cycles = CYC_W'(2);
    end
    return s;
  endfunction

  function automatic steer_t branchSteer(input logic hit);
    steer_t s;
    s.load   = 1'b0;
    s.target = hit ? TGT_SHORT : TGT_INC1;
    s.cycles = hit ? CYC_W'(2) : CYC_W'(1);
    return s;
  endfunction

  always_comb begin
    steer.load   = 1'b0;
    steer.target = TGT_INC1;
    steer.cycles = CYC_W'(1);
    case (instClass)
      CLS_RJMP:    begin steer.target = TGT_LONG; steer.cycles = CYC_W'(2); end
      CLS_RCALL:   begin steer.target = TGT_LONG; steer.cycles = CYC_W'(3); end
      CLS_IJMP:    begin steer.target = TGT_ZPTR; steer.cycles = CYC_W'(2); end
      CLS_ICALL:   begin steer.target = TGT_ZPTR; steer.cycles = CYC_W'(3); end
      CLS_RET:     begin steer.target = TGT_HOLD; steer.cycles = CYC_W'(4); end
      CLS_BRFLAG:  steer = branchSteer(flagHit);
      CLS_BRSIGN:  steer = branchSteer(signedHit);
      CLS_SKIPEQ:  steer = skipSteer(eqHit, nextIsLong);
      CLS_SKIPBIT: steer = skipSteer(bitHit, nextIsLong);
      default:     begin steer.target = TGT_INC1; steer.cycles = CYC_W'(1); end
    endcase
    steer.load = instValid;
  end

  // R6
  signed_ge_taken_chk: assert property (@(posedge clk) disable iff (!rstN)
    (instValid && instClass == 4'd7 && !senseSet &&
     statusBits[N_POS] == statusBits[V_POS])
    |-> (steer.target == TGT_SHORT && steer.cycles == 3'd2));

  // R6
  signed_lt_blocked_chk: assert property (@(posedge clk) disable iff (!rstN)
    (instValid && instClass == 4'd7 && senseSet &&
     statusBits[N_POS] == statusBits[V_POS])
    |-> (steer.target == TGT_INC1 && steer.cycles == 3'd1));

  // R7
  long_skip_cost_chk: assert property (@(posedge clk) disable iff (!rstN)
    (instValid && instClass == 4'd8 && regsEqual && nextIsLong)
    |-> (steer.target == TGT_INC3 && steer.cycles == 3'd3));

  // R8
  bit_skip_miss_chk: assert property (@(posedge clk) disable iff (!rstN)
    (instValid && instClass == 4'd9 && testBit != senseSet)
    |-> (steer.target == TGT_INC1 && steer.cycles == 3'd1));

endmodule

// File: rtl/pc_steer_datapath.sv
module pc_steer_datapath
  import pc_steer_pkg::*;
#(
  parameter int PC_W     = 10,
  parameter int OFF_W    = 12,
  parameter int BR_OFF_W = 7,
  parameter int PTR_W    = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  steer_t           steer,
  input  logic [PC_W-1:0]  curPc,
  input  logic [OFF_W-1:0] offset,
  input  logic [PTR_W-1:0] zPtr,
  output logic [PC_W-1:0]  nextPc,
  output logic [CYC_W-1:0] cycleCount,
  output logic             resultValid
);

  logic [PC_W-1:0] shortExt;
  logic [PC_W-1:0] longExt;
  logic [PC_W-1:0] targetPc;

  generate
    if (PC_W > BR_OFF_W) begin : g_short_ext
      assign shortExt = {{(PC_W-BR_OFF_W){offset[BR_OFF_W-1]}}, offset[BR_OFF_W-1:0]};
    end else begin : g_short_trunc
      assign shortExt = offset[PC_W-1:0];
    end
    if (PC_W > OFF_W) begin : g_long_ext
      assign longExt = {{(PC_W-OFF_W){offset[OFF_W-1]}}, offset};
    end else begin : g_long_trunc
      assign longExt = offset[PC_W-1:0];
    end
  endgenerate

  always_comb begin
    case (steer.target)
      TGT_INC2:  targetPc = curPc + PC_W'(2);
      TGT_INC3:  targetPc = curPc + PC_W'(3);
      TGT_SHORT: targetPc = curPc + shortExt + PC_W'(1);
      TGT_LONG:  targetPc = curPc + longExt + PC_W'(1);
      TGT_ZPTR:  targetPc = zPtr[PC_W-1:0];
      TGT_HOLD:  targetPc = curPc;
      default:   targetPc = curPc + PC_W'(1);
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nextPc      <= '0;
      cycleCount  <= '0;
      resultValid <= 1'b0;
    end else begin
      resultValid <= steer.load;
      if (steer.load) begin
        nextPc     <= targetPc;
        cycleCount <= steer.cycles;
      end
    end
  end

  // R2
  result_follows_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    steer.load |=> resultValid);

  // R2
  idle_holds_chk: assert property (@(posedge clk) disable iff (!rstN)
    !steer.load |=> (!resultValid && $stable(nextPc) && $stable(cycleCount)));

  // R4
  indirect_target_chk: assert property (@(posedge clk) disable iff (!rstN)
    (steer.load && steer.target == TGT_ZPTR) |=> (nextPc == $past(zPtr[PC_W-1:0])));

  // R9
  nonzero_cost_chk: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |-> (cycleCount != '0));

endmodule

// File: rtl/pc_steer_unit.sv
module pc_steer_unit
  import pc_steer_pkg::*;
#(
  parameter int PC_W     = 10,
  parameter int OFF_W    = 12,
  parameter int BR_OFF_W = 7,
  parameter int PTR_W    = 16,
  parameter int STAT_W   = 8,
  localparam int SEL_W   = $clog2(STAT_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              instValid,
  input  logic [3:0]        instClass,
  input  logic [PC_W-1:0]   curPc,
  input  logic [OFF_W-1:0]  offset,
  input  logic [PTR_W-1:0]  zPtr,
  input  logic [STAT_W-1:0] statusBits,
  input  logic [SEL_W-1:0]  flagSel,
  input  logic              senseSet,
  input  logic              testBit,
  input  logic              regsEqual,
  input  logic              nextIsLong,
  output logic [PC_W-1:0]   nextPc,
  output logic [CYC_W-1:0]  cycleCount,
  output logic              resultValid
);

  steer_t steer;

  pc_steer_ctrl #(.STAT_W(STAT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .instValid(instValid), .instClass(instClass),
    .statusBits(statusBits), .flagSel(flagSel), .senseSet(senseSet),
    .testBit(testBit), .regsEqual(regsEqual), .nextIsLong(nextIsLong),
    .steer(steer)
  );

  pc_steer_datapath #(.PC_W(PC_W), .OFF_W(OFF_W), .BR_OFF_W(BR_OFF_W), .PTR_W(PTR_W)) u_dp (
    .clk(clk), .rstN(rstN), .steer(steer), .curPc(curPc), .offset(offset),
    .zPtr(zPtr), .nextPc(nextPc), .cycleCount(cycleCount), .resultValid(resultValid)
  );

endmodule

// File: tb/pc_steer_unit_bench.sv
module pc_steer_unit_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        instValid = 1'b0;
  logic [3:0]  instClass = '0;
  logic [9:0]  curPc = '0;
  logic [11:0] offset = '0;
  logic [15:0] zPtr = '0;
  logic [7:0]  statusBits = '0;
  logic [2:0]  flagSel = '0;
  logic        senseSet = 1'b0;
  logic        testBit = 1'b0;
  logic        regsEqual = 1'b0;
  logic        nextIsLong = 1'b0;
  logic [9:0]  nextPc;
  logic [2:0]  cycleCount;
  logic        resultValid;

  int compared = 0;
  int mismatched = 0;

  always #10 clk = ~clk;

  pc_steer_unit u_pc_steer_unit (
    .clk(clk), .rstN(rstN), .instValid(instValid), .instClass(instClass),
    .curPc(curPc), .offset(offset), .zPtr(zPtr), .statusBits(statusBits),
    .flagSel(flagSel), .senseSet(senseSet), .testBit(testBit),
    .regsEqual(regsEqual), .nextIsLong(nextIsLong), .nextPc(nextPc),
    .cycleCount(cycleCount), .resultValid(resultValid)
  );

  typedef struct packed {
    logic [3:0]  req;
    logic [3:0]  cls;
    logic [9:0]  pc;
    logic [11:0] off;
    logic [15:0] z;
    logic [7:0]  stat;
    logic [2:0]  sel;
    logic        sense;
    logic        tbit;
    logic        eq;
    logic        lng;
    logic [9:0]  expPc;
    logic [2:0]  expCyc;
  } vec_t;

  localparam int NVEC = 22;
  localparam logic [73:0] VECS [0:NVEC-1] = '{
    // R10 sequential
    {4'd10, 4'd0, 10'd10,   12'h000, 16'h0000, 8'h00, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 10'd11,   3'd1},
    // R3 jump forward and backward
    {4'd3,  4'd1, 10'd100,  12'h014, 16'h0000, 8'h00, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 10'd121,  3'd2},
    {4'd3,  4'd1, 10'd100,  12'hFFF, 16'h0000, 8'h00, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 10'd100,  3'd2},
    // R11 call wrapping below zero
    {4'd11, 4'd2, 10'd5,    12'hFF6, 16'h0000, 8'h00, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 10'd1020, 3'd3},
    // R11 jump wrapping above top
    {4'd11, 4'd1, 10'd1023, 12'h000, 16'h0000, 8'h00, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 10'd0,    3'd2},
    // R4 indirect
    {4'd4,  4'd3, 10'd7,    12'h000, 16'hABCD, 8'h00, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 10'd973,  3'd2},
    {4'd4,  4'd4, 10'd7,    12'h000, 16'h0012, 8'h00, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 10'd18,   3'd3},
    // R5 flag branch taken, not taken, upper offset bits ignored
    {4'd5,  4'd6, 10'd200,  12'h005, 16'h0000, 8'h02, 3'd1, 1'b1, 1'b0, 1'b0, 1'b0, 10'd206,  3'd2},
    {4'd5,  4'd6, 10'd200,  12'h005, 16'h0000, 8'h02, 3'd1, 1'b0, 1'b0, 1'b0, 1'b0, 10'd201,  3'd1},
    {4'd5,  4'd6, 10'd200,  12'h0C0, 16'h0000, 8'h80, 3'd7, 1'b1, 1'b0, 1'b0, 1'b0, 10'd137,  3'd2},
    // R6 signed branches
    {4'd6,  4'd7, 10'd50,   12'h003, 16'h0000, 8'h0C, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 10'd54,   3'd2},
    {4'd6,  4'd7, 10'd50,   12'h003, 16'h0000, 8'h04, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 10'd51,   3'd1},
    {4'd6,  4'd7, 10'd50,   12'h003, 16'h0000, 8'h08, 3'd0, 1'b1, 1'b0, 1'b0, 1'b0, 10'd54,   3'd2},
    // R7 equality skip
    {4'd7,  4'd8, 10'd300,  12'h000, 16'h0000, 8'h00, 3'd0, 1'b0, 1'b0, 1'b1, 1'b0, 10'd302,  3'd2},
    {4'd7,  4'd8, 10'd300,  12'h000, 16'h0000, 8'h00, 3'd0, 1'b0, 1'b0, 1'b1, 1'b1, 10'd303,  3'd3},
    {4'd7,  4'd8, 10'd300,  12'h000, 16'h0000, 8'h00, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1, 10'd301,  3'd1},
    // R8 bit skip
    {4'd8,  4'd9, 10'd300,  12'h000, 16'h0000, 8'h00, 3'd0, 1'b1, 1'b1, 1'b0, 1'b0, 10'd302,  3'd2},
    {4'd8,  4'd9, 10'd300,  12'h000, 16'h0000, 8'h00, 3'd0, 1'b0, 1'b1, 1'b0, 1'b1, 10'd301,  3'd1},
    {4'd8,  4'd9, 10'd300,  12'h000, 16'h0000, 8'h00, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1, 10'd303,  3'd3},
    // R9 return
    {4'd9,  4'd5, 10'd77,   12'h000, 16'h0000, 8'h00, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 10'd77,   3'd4},
    // R10 unused code
    {4'd10, 4'd12, 10'd77,  12'h000, 16'h0000, 8'h00, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 10'd78,   3'd1},
    // R11 long skip across the top
    {4'd11, 4'd8, 10'd1022, 12'h000, 16'h0000, 8'h00, 3'd0, 1'b0, 1'b0, 1'b1, 1'b1, 10'd1,    3'd3}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic apply(input vec_t v);
    @(negedge clk);
    instValid  = 1'b1;
    instClass  = v.cls;
    curPc      = v.pc;
    offset     = v.off;
    zPtr       = v.z;
    statusBits = v.stat;
    flagSel    = v.sel;
    senseSet   = v.sense;
    testBit    = v.tbit;
    regsEqual  = v.eq;
    nextIsLong = v.lng;
    @(negedge clk);
    instValid  = 1'b0;
  endtask

  initial begin
    #2_000_000;
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    vec_t v;
    logic [9:0] heldPc;
    logic [2:0] heldCyc;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 valid", 32'(resultValid), 0);
    check("R1 pc", 32'(nextPc), 0);
    check("R1 cycles", 32'(cycleCount), 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 after release", 32'(nextPc), 0);

    for (int i = 0; i < NVEC; i++) begin
      v = vec_t'(VECS[i]);
      apply(v);
      check($sformatf("R%0d vec %0d valid", v.req, i), 32'(resultValid), 1);
      check($sformatf("R%0d vec %0d pc", v.req, i), 32'(nextPc), 32'(v.expPc));
      check($sformatf("R%0d vec %0d cycles", v.req, i), 32'(cycleCount), 32'(v.expCyc));
    end

    // R2 idle cycle with busy inputs leaves outputs alone
    heldPc = nextPc;
    heldCyc = cycleCount;
    instClass = 4'd3;
    zPtr = 16'h0155;
    curPc = 10'd400;
    @(negedge clk);
    check("R2 idle valid", 32'(resultValid), 0);
    check("R2 idle pc", 32'(nextPc), 32'(heldPc));
    check("R2 idle cycles", 32'(cycleCount), 32'(heldCyc));

    // R2 back-to-back requests, one result per edge
    @(negedge clk);
    instValid = 1'b1; instClass = 4'd1; curPc = 10'd10; offset = 12'h002;
    @(negedge clk);
    check("R2 b2b first pc", 32'(nextPc), 13);
    instClass = 4'd5; curPc = 10'd600;
    @(negedge clk);
    instValid = 1'b0;
    check("R2 b2b second pc", 32'(nextPc), 600);
    check("R2 b2b second cycles", 32'(cycleCount), 4);
    @(negedge clk);
    check("R2 strobe drops", 32'(resultValid), 0);

    // R1 reset in mid-run clears outputs
    rstN = 1'b0;
    @(negedge clk);
    check("R1 midrun pc", 32'(nextPc), 0);
    check("R1 midrun cycles", 32'(cycleCount), 0);
    rstN = 1'b1;
    @(negedge clk);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule